// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block keeps a signed accumulator twice as wide as its operands and updates it in a single clock cycle. Each cycle a command code selects one of four actions: leave the accumulator alone, add the signed product of the two operands to it, take that product away from it, or return a scaled slice of it while clearing it. With the default 32-bit operands the accumulator is 64 bits wide. Products are full width and nothing saturates: any sum that runs past the top bit wraps.

Two special-register views give software a path to the accumulator, one for the low half and one for the high half. A read returns the selected half with no delay. A write replaces only the selected half. If a write arrives in the same cycle as an active command, the command takes the accumulator and the write is discarded.

Read-and-clear returns the accumulator shifted right arithmetically by `RC_SHIFT` places and cut to operand width. With the defaults that result is accumulator bits 59 down to 28. The result appears combinationally in the cycle the command is presented, and the clear happens at the closing edge of that cycle. A command issued on the cycle right after an accumulate therefore sees the updated value, with no stall.

Top module: `mac_acc_unit`

## Requirements
- R1: While reset (`rst_n` low) is held, and on release, both accumulator halves read as zero.
- R2: With `cmd` = 2'b01 (multiply-add), the accumulator becomes its old value plus the signed product of `op_a` and `op_b`, modulo 2^(2·OP_W), at the next rising edge.
- R3: With `cmd` = 2'b10 (multiply-subtract), the accumulator becomes its old value minus the signed product of `op_a` and `op_b`, modulo 2^(2·OP_W), at the next rising edge.
- R4: With `cmd` = 2'b11 (read-and-clear), `rc_result` shows in the same cycle the accumulator shifted right arithmetically by `RC_SHIFT` and truncated to `OP_W` bits. With any other `cmd`, `rc_result` is zero.
- R5: A read-and-clear leaves both accumulator halves at zero after its edge.
- R6: Every command finishes in one cycle. A command on the cycle right after an accumulate works on the updated accumulator.
- R7: `sr_rdata` shows, combinationally, accumulator bits [OP_W-1:0] when `sr_sel` = 0 and bits [2·OP_W-1:OP_W] when `sr_sel` = 1.
- R8: With `cmd` = 2'b00 and `sr_wr_en` high, the half chosen by `sr_sel` takes `sr_wdata` at the edge and the other half keeps its value.
- R9: When `sr_wr_en` is high together with a non-idle `cmd`, the write is dropped and the accumulator takes the command's result.
- R10: With `cmd` = 2'b00 and `sr_wr_en` low, the accumulator holds its value whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | OP_W | First signed multiplicand |
| op_b | input | OP_W | Second signed multiplicand |
| cmd | input | 2 | 00 idle, 01 multiply-add, 10 multiply-subtract, 11 read-and-clear |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_sel | input | 1 | Half select: 0 low, 1 high |
| sr_wdata | input | OP_W | Special-register write data |
| sr_rdata | output | OP_W | Selected accumulator half |
| rc_result | output | OP_W | Scaled read-and-clear result, zero otherwise |

## Verification
A special-register write and an accumulator command can fall in the same cycle and contend for the same register. The bench provokes this by raising the write strobe, with a data value distinct from the expected result, alongside multiply-add, multiply-subtract and read-and-clear on each half. It then reads both halves back. It judges the collision correct only when the halves match the command's arithmetic result and no trace of the write data remains. A small 4-bit configuration allows a sweep over every operand pair, so wrap-around and sign handling are covered completely.

// File: rtl/mac_acc_pkg.sv
`timescale 1ns/1ps
package mac_acc_pkg;

    typedef enum logic [1:0] {
        MAC_IDLE = 2'b00,
        MAC_MADD = 2'b01,
        MAC_MSUB = 2'b10,
        MAC_RCLR = 2'b11
    } mac_cmd_e;

    localparam int unsigned HALF_COUNT = 2;

endpackage

// File: rtl/mac_acc_mul.sv
`timescale 1ns/1ps
// Full-width signed product of two operands, purely combinational.
module mac_acc_mul #(
    parameter int unsigned OP_W = 32
) (
    input  logic [OP_W-1:0]          mul_a,
    input  logic [OP_W-1:0]          mul_b,
    output logic signed [2*OP_W-1:0] mul_p
);
    localparam int unsigned P_W = 2 * OP_W;

    logic signed [P_W-1:0] prod_w;

    always_comb begin
        prod_w = $signed(mul_a) * $signed(mul_b);
    end

    assign mul_p = prod_w;

endmodule

// File: rtl/mac_acc_core.sv
`timescale 1ns/1ps
// Accumulator storage kept as independently enabled halves.
module mac_acc_core
    import mac_acc_pkg::*;
#(
    parameter int unsigned OP_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  mac_cmd_e                 cmd_i,
    input  logic signed [2*OP_W-1:0] prod_i,
    input  logic [HALF_COUNT-1:0]    wr_half_i,
    input  logic [OP_W-1:0]          wdata_i,
    output logic [2*OP_W-1:0]        acc_o
);
    localparam int unsigned ACC_W = 2 * OP_W;

    logic [OP_W-1:0]  half_q [HALF_COUNT];
    logic [ACC_W-1:0] acc_now;
    logic [ACC_W-1:0] acc_nxt;
    logic             cmd_live;

    always_comb begin
        unique case (cmd_i)
            MAC_IDLE: acc_nxt = acc_now;
            MAC_MADD: acc_nxt = acc_now + prod_i;
            MAC_MSUB: acc_nxt = acc_now - prod_i;
            MAC_RCLR: acc_nxt = '0;
        endcase
        cmd_live = (cmd_i != MAC_IDLE);
    end

    for (genvar h = 0; h < HALF_COUNT; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (cmd_live) begin
                half_q[h] <= acc_nxt[h*OP_W +: OP_W];
            end else if (wr_half_i[h]) begin
                half_q[h] <= wdata_i;
            end
        end
        assign acc_now[h*OP_W +: OP_W] = half_q[h];
    end

    assign acc_o = acc_now;

endmodule

// File: rtl/mac_acc_sreg.sv
`timescale 1ns/1ps
// Special-register view: half read mux, write decode, scaled result.
module mac_acc_sreg
    import mac_acc_pkg::*;
#(
    parameter int unsigned OP_W     = 32,
    parameter int unsigned RC_SHIFT = 28
) (
    input  mac_cmd_e              cmd_i,
    input  logic [2*OP_W-1:0]     acc_i,
    input  logic                  wr_en_i,
    input  logic                  sel_i,
    output logic [HALF_COUNT-1:0] wr_half_o,
    output logic [OP_W-1:0]       rdata_o,
    output logic [OP_W-1:0]       rc_o
);
    localparam int unsigned ACC_W = 2 * OP_W;

    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        wr_half_o = '0;
        if (wr_en_i && (cmd_i == MAC_IDLE)) begin
            wr_half_o[sel_i] = 1'b1;
        end
        rdata_o = sel_i ? acc_i[ACC_W-1:OP_W] : acc_i[OP_W-1:0];
        scaled  = $signed(acc_i) >>> RC_SHIFT;
        rc_o    = (cmd_i == MAC_RCLR) ? scaled[OP_W-1:0] : '0;
    end

endmodule

// File: rtl/mac_acc_unit.sv
`timescale 1ns/1ps
module mac_acc_unit
    import mac_acc_pkg::*;
#(
    parameter int unsigned OP_W     = 32,
    parameter int unsigned RC_SHIFT = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic [1:0]      cmd,
    input  logic            sr_wr_en,
    input  logic            sr_sel,
    input  logic [OP_W-1:0] sr_wdata,
    output logic [OP_W-1:0] sr_rdata,
    output logic [OP_W-1:0] rc_result
);
    localparam int unsigned ACC_W = 2 * OP_W;

    mac_cmd_e                cmd_e;
    logic signed [ACC_W-1:0] prod;
    logic [HALF_COUNT-1:0]   wr_half;
    logic [ACC_W-1:0]        acc_q;

    assign cmd_e = mac_cmd_e'(cmd);

    mac_acc_mul #(.OP_W(OP_W)) u_mul (
        .mul_a (op_a),
        .mul_b (op_b),
        .mul_p (prod)
    );

    mac_acc_core #(.OP_W(OP_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_e),
        .prod_i    (prod),
        .wr_half_i (wr_half),
        .wdata_i   (sr_wdata),
        .acc_o     (acc_q)
    );

    mac_acc_sreg #(.OP_W(OP_W), .RC_SHIFT(RC_SHIFT)) u_sreg (
        .cmd_i     (cmd_e),
        .acc_i     (acc_q),
        .wr_en_i   (sr_wr_en),
        .sel_i     (sr_sel),
        .wr_half_o (wr_half),
        .rdata_o   (sr_rdata),
        .rc_o      (rc_result)
    );

endmodule

// File: rtl/mac_acc_chk.sv
`timescale 1ns/1ps
module mac_acc_chk #(
    parameter int unsigned OP_W     = 32,
    parameter int unsigned RC_SHIFT = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              sr_wr_en,
    input logic              sr_sel,
    input logic [OP_W-1:0]   sr_wdata,
    input logic [OP_W-1:0]   rc_result,
    input logic [2*OP_W-1:0] acc_q
);
    localparam int unsigned ACC_W = 2 * OP_W;

    logic signed [ACC_W-1:0] chk_prod;
    assign chk_prod = $signed(op_a) * $signed(op_b);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> acc_q == '0); // R1
    AST_MADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b01 |=> acc_q == $past(acc_q) + $past(chk_prod)); // R2
    AST_MSUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b10 |=> acc_q == $past(acc_q) - $past(chk_prod)); // R3
    AST_RC_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b11 |-> rc_result == acc_q[RC_SHIFT +: OP_W]); // R4
    AST_RC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b11 |-> rc_result == '0); // R4
    AST_RC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b11 |=> acc_q == '0); // R5
    AST_WR_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00 && sr_wr_en && !sr_sel) |=>
        (acc_q[OP_W-1:0] == $past(sr_wdata) && $stable(acc_q[ACC_W-1:OP_W]))); // R8
    AST_WR_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00 && sr_wr_en && sr_sel) |=>
        (acc_q[ACC_W-1:OP_W] == $past(sr_wdata) && $stable(acc_q[OP_W-1:0]))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00 && !sr_wr_en) |=> $stable(acc_q)); // R10

endmodule

bind mac_acc_unit mac_acc_chk #(.OP_W(OP_W), .RC_SHIFT(RC_SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .op_a      (op_a),
    .op_b      (op_b),
    .sr_wr_en  (sr_wr_en),
    .sr_sel    (sr_sel),
    .sr_wdata  (sr_wdata),
    .rc_result (rc_result),
    .acc_q     (acc_q)
);

// File: tb/sim_mac_acc_unit.sv
`timescale 1ns/1ps
module sim_mac_acc_unit;
    localparam int W  = 4;
    localparam int AW = 2 * W;
    localparam int SH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [1:0]    cmd = 2'b00;
    logic          sr_wr_en = 1'b0;
    logic          sr_sel = 1'b0;
    logic [W-1:0]  sr_wdata = '0;
    logic [W-1:0]  sr_rdata;
    logic [W-1:0]  rc_result;

    logic [AW-1:0] model = '0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mac_acc_unit #(.OP_W(W), .RC_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cmd(cmd),
        .sr_wr_en(sr_wr_en), .sr_sel(sr_sel), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .rc_result(rc_result)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rc_expect(input logic [AW-1:0] acc);
        logic signed [AW-1:0] s;
        s = $signed(acc) >>> SH;
        return s[W-1:0];
    endfunction

    // Reads both halves between edges and compares with the model.
    task automatic read_check(input string req);
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        sr_sel = 1'b0; #1; lo = sr_rdata;
        sr_sel = 1'b1; #1; hi = sr_rdata;
        chk(req, {hi, lo}, model);
    endtask

    task automatic step(input logic [1:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic we, input logic sel, input logic [W-1:0] wd);
        logic signed [AW-1:0] p;
        @(negedge clk);
        cmd = c; op_a = a; op_b = b; sr_wr_en = we; sr_sel = sel; sr_wdata = wd;
        #1;
        if (c == 2'b11) chk("R4 rc value", rc_result, rc_expect(model));
        else            chk("R4 rc idle", rc_result, '0);
        @(posedge clk); #1;
        cmd = 2'b00; sr_wr_en = 1'b0;
        p = $signed(a) * $signed(b);
        case (c)
            2'b01: model = model + p;
            2'b10: model = model - p;
            2'b11: model = '0;
            default: if (we) begin
                if (sel) model[AW-1:W] = wd;
                else     model[W-1:0]  = wd;
            end
        endcase
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1; read_check("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; read_check("R1 after release");

        // R2: every operand pair accumulated, wrapping included
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(2'b01, W'(a), W'(b), 1'b0, 1'b0, '0);
                read_check("R2 madd");
            end
        end

        // R4/R5/R6: read-and-clear right after accumulate
        step(2'b01, 4'h7, 4'h7, 1'b0, 1'b0, '0);
        step(2'b11, '0, '0, 1'b0, 1'b0, '0);
        read_check("R5 clear");

        // R3: every pair subtracted; periodic clear right after (R6)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(2'b10, W'(a), W'(b), 1'b0, 1'b0, '0);
                read_check("R3 msub");
            end
            step(2'b11, '0, '0, 1'b0, 1'b0, '0);
            read_check("R6 clear after msub");
        end

        // R6: negative accumulation then immediate clear
        step(2'b01, 4'h8, 4'h7, 1'b0, 1'b0, '0);
        step(2'b11, '0, '0, 1'b0, 1'b0, '0);
        read_check("R6 b2b");

        // R7/R8: each half written alone, every value
        for (int v = 0; v < 16; v++) begin
            step(2'b00, '0, '0, 1'b1, 1'b0, W'(v));
            read_check("R8 low write");
            step(2'b00, '0, '0, 1'b1, 1'b1, W'(15 - v));
            read_check("R7 high write");
        end

        // R9: write collides with each command
        for (int s = 0; s < 2; s++) begin
            step(2'b00, '0, '0, 1'b1, 1'b0, 4'h3);
            step(2'b00, '0, '0, 1'b1, 1'b1, 4'h1);
            step(2'b01, 4'h5, 4'h3, 1'b1, s[0], 4'hA);
            read_check("R9 madd wins");
            step(2'b10, 4'hD, 4'h6, 1'b1, s[0], 4'h9);
            read_check("R9 msub wins");
            step(2'b11, '0, '0, 1'b1, s[0], 4'hF);
            read_check("R9 rclr wins");
        end

        // R10: idle with moving operands holds the value
        step(2'b00, '0, '0, 1'b1, 1'b0, 4'hB);
        step(2'b00, '0, '0, 1'b1, 1'b1, 4'h6);
        for (int k = 0; k < 8; k++) begin
            step(2'b00, W'(k + 3), W'(11 - k), 1'b0, k[0], W'(k));
            read_check("R10 hold");
        end
        step(2'b11, '0, '0, 1'b0, 1'b0, '0);
        read_check("R5 final clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule